// File: doc/BRIEF.md
# Fault and Wake Interrupt Reporter

This block gathers fault flags and wake flags from the rest of a power-management die and tells a host controller about them. A new event drives an active-low interrupt pin low for a fixed number of clock cycles. The event is also recorded in a one-hot source mask that the host reads over the serial register interface. Fault flags are honoured in the two running modes. Wake flags are honoured only while the die is in its low-power STOP mode.

The host learns about an event from the interrupt pulse and then reads the source register. The read strobe clears the mask and the pending flag, so each event is delivered once. An event that lands on the same cycle as the read is not lost: it forms the new content of the mask. The input comparators and thresholds sit outside this block.

Top module: `irq_reporter`

## Requirements
- R1: While reset is asserted and after it is released, `irq_n_o` is high, `src_o` is zero and `pend_o` is low.
- R2: A rising edge on any `fault_i` bit while `mode_i` is NORMAL (0) or STOP (1) drives `irq_n_o` low from the clock edge that samples it, for exactly `PULSE_LEN` cycles (4 by default).
- R3: A fault flag that stays high gives only one pulse. A further pulse needs the flag to fall and rise again.
- R4: A rising edge on any `wake_i` bit while `mode_i` is STOP (1) raises the pulse and sets its mask bit.
- R5: A wake edge in any mode other than STOP gives no pulse and leaves the mask unchanged.
- R6: A fault edge while `mode_i` is SLEEP (2) or RESET (3) gives no pulse and leaves the mask unchanged.
- R7: Mask bit positions are fixed. Bit 0 is regulator thermal pre-warning. Bits 1, 2 and 3 are thermal shutdown of switches 1, 2 and 3. Bit 4 is supply overvoltage and bit 5 is supply undervoltage. Bits 6, 7 and 8 are local wake 1, local wake 2 and bus wake. Events in the same cycle, and events before a read, are ORed into the mask.
- R8: `pend_o` is high exactly when the latched mask is non-zero.
- R9: A read strobe `rd_stb_i` with no new event clears `src_o` and `pend_o` on the next edge.
- R10: An event on the same cycle as a read strobe is kept. Older bits are cleared and the new bits remain, with `pend_o` high.
- R11: A qualifying event during a pulse restarts the pulse, so `irq_n_o` stays low for `PULSE_LEN` cycles after the latest event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 6 | Fault flags, level, bit order as the mask |
| wake_i | input | 3 | Wake flags: local 1, local 2, bus |
| mode_i | input | 2 | Operating mode: 0 NORMAL, 1 STOP, 2 SLEEP, 3 RESET |
| rd_stb_i | input | 1 | One-cycle strobe: host read the source register |
| irq_n_o | output | 1 | Active-low interrupt pulse |
| src_o | output | 9 | One-hot latched event source mask |
| pend_o | output | 1 | Source data pending transfer |

## Verification
A stuck edge-detect register shows up on the pin one cycle after a flag change, either as a missing pulse or as repeated pulses for a held fault. A wrong pulse counter shows up as a low time that differs from `PULSE_LEN`, or as a low time that does not stretch after a second event, within a few cycles of the trigger. A bad mode qualifier or a bad read-clear path shows in `src_o` and `pend_o` on the edge right after the stimulus. The checks sample one cycle after each input change and count the low time of every pulse.

// File: rtl/irq_rep_pkg.sv
package irq_rep_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_STOP   = 2'd1,
    MODE_SLEEP  = 2'd2,
    MODE_RESET  = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irq_evt_qual.sv
module irq_evt_qual
  import irq_rep_pkg::*;
#(
  parameter int N_FAULT = 6,
  parameter int N_WAKE  = 3,
  localparam int N_EVT  = N_FAULT + N_WAKE
) (
  input  pwr_mode_e          mode_i,
  input  logic [N_FAULT-1:0] fault_rise_i,
  input  logic [N_WAKE-1:0]  wake_rise_i,
  output logic [N_EVT-1:0]   evt_o
);
  logic fault_en;
  logic wake_en;

  always_comb begin
    fault_en = (mode_i == MODE_NORMAL) || (mode_i == MODE_STOP);
    wake_en  = (mode_i == MODE_STOP);
  end

  for (genvar i = 0; i < N_FAULT; i++) begin : g_fault
    assign evt_o[i] = fault_rise_i[i] & fault_en;
  end
  for (genvar j = 0; j < N_WAKE; j++) begin : g_wake
    assign evt_o[N_FAULT+j] = wake_rise_i[j] & wake_en;
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int PULSE_LEN = 4,
  localparam int CNT_W    = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic irq_n_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = trig_i || (cnt_q != '0);
    if (trig_i) cnt_d = CNT_W'(PULSE_LEN);
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign irq_n_o = (cnt_q == '0);
endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         rd_i,
  output logic [W-1:0] src_o,
  output logic         pend_o
);
  logic [W-1:0] src_q, src_d;
  logic         pend_q, pend_d;
  logic         upd_en;

  always_comb begin
    upd_en = rd_i || (evt_i != '0);
    src_d  = (rd_i ? '0 : src_q) | evt_i;
    pend_d = (rd_i ? 1'b0 : pend_q) | (|evt_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      src_q  <= src_d;
      pend_q <= pend_d;
    end
  end

  assign src_o  = src_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_reporter.sv
module irq_reporter
  import irq_rep_pkg::*;
#(
  parameter int N_FAULT   = 6,
  parameter int N_WAKE    = 3,
  parameter int PULSE_LEN = 4,
  localparam int N_EVT    = N_FAULT + N_WAKE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FAULT-1:0] fault_i,
  input  logic [N_WAKE-1:0]  wake_i,
  input  logic [1:0]         mode_i,
  input  logic               rd_stb_i,
  output logic               irq_n_o,
  output logic [N_EVT-1:0]   src_o,
  output logic               pend_o
);
  logic [N_EVT-1:0] rise;
  logic [N_EVT-1:0] evt;
  pwr_mode_e        mode;

  assign mode = pwr_mode_e'(mode_i);

  irq_edge_det #(.W(N_EVT)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({wake_i, fault_i}),
    .rise_o (rise)
  );

  irq_evt_qual #(.N_FAULT(N_FAULT), .N_WAKE(N_WAKE)) u_qual (
    .mode_i       (mode),
    .fault_rise_i (rise[N_FAULT-1:0]),
    .wake_rise_i  (rise[N_EVT-1:N_FAULT]),
    .evt_o        (evt)
  );

  irq_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (|evt),
    .irq_n_o (irq_n_o)
  );

  irq_src_latch #(.W(N_EVT)) u_src (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt),
    .rd_i   (rd_stb_i),
    .src_o  (src_o),
    .pend_o (pend_o)
  );
endmodule

// File: rtl/irq_reporter_chk.sv
module irq_reporter_chk #(
  parameter int N_FAULT = 6,
  parameter int N_WAKE  = 3,
  localparam int N_EVT  = N_FAULT + N_WAKE
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             rd_stb_i,
  input logic [N_EVT-1:0] evt,
  input logic             irq_n_o,
  input logic [N_EVT-1:0] src_o,
  input logic             pend_o
);
  assert_evt_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> !irq_n_o);

  assert_fall_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> $past(|evt));

  assert_wake_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd1 && !rd_stb_i) |=>
      ((src_o[N_EVT-1:N_FAULT] & ~$past(src_o[N_EVT-1:N_FAULT])) == '0));

  assert_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o == (src_o != '0));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && evt == '0) |=> (src_o == '0 && !pend_o));

  assert_read_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && evt != '0) |=> (src_o == $past(evt) && pend_o));
endmodule

bind irq_reporter irq_reporter_chk #(.N_FAULT(N_FAULT), .N_WAKE(N_WAKE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_i   (mode_i),
  .rd_stb_i (rd_stb_i),
  .evt      (evt),
  .irq_n_o  (irq_n_o),
  .src_o    (src_o),
  .pend_o   (pend_o)
);

// File: tb/irq_reporter_test.sv
module irq_reporter_test;
  localparam int PL = 4;

  logic       clk;
  logic       rst_n;
  logic [5:0] fault_i;
  logic [2:0] wake_i;
  logic [1:0] mode_i;
  logic       rd_stb_i;
  logic       irq_n_o;
  logic [8:0] src_o;
  logic       pend_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_reporter #(.PULSE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .wake_i(wake_i),
    .mode_i(mode_i), .rd_stb_i(rd_stb_i), .irq_n_o(irq_n_o),
    .src_o(src_o), .pend_o(pend_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // req[26:23] mode[22:21] fault[20:15] wake[14:12] rd[11] src[10:2] pend[1] irq_n[0]
  localparam logic [26:0] VEC [9] = '{
    {4'd2,  2'd0, 6'b000001, 3'b000, 1'b0, 9'h001, 1'b1, 1'b0}, // R2 R7
    {4'd9,  2'd0, 6'b000000, 3'b000, 1'b1, 9'h000, 1'b0, 1'b1}, // R9
    {4'd4,  2'd1, 6'b000000, 3'b001, 1'b0, 9'h040, 1'b1, 1'b0}, // R4
    {4'd5,  2'd0, 6'b000000, 3'b100, 1'b0, 9'h040, 1'b1, 1'b1}, // R5
    {4'd10, 2'd1, 6'b000110, 3'b010, 1'b1, 9'h086, 1'b1, 1'b0}, // R10 R7
    {4'd6,  2'd2, 6'b111111, 3'b000, 1'b0, 9'h086, 1'b1, 1'b1}, // R6 sleep
    {4'd6,  2'd3, 6'b110000, 3'b000, 1'b1, 9'h000, 1'b0, 1'b1}, // R6 reset mode
    {4'd7,  2'd0, 6'b110000, 3'b000, 1'b0, 9'h030, 1'b1, 1'b0}, // R7 R8
    {4'd9,  2'd0, 6'b000000, 3'b000, 1'b1, 9'h000, 1'b0, 1'b1}  // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    fault_i  = '0;
    wake_i   = '0;
    rd_stb_i = 1'b0;
    mode_i   = 2'd0;
    repeat (n) @(negedge clk);
  endtask

  task automatic count_low(input int n, output int low);
    low = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!irq_n_o) low++;
    end
  endtask

  initial begin
    int low;
    fault_i = '0; wake_i = '0; mode_i = 2'd0; rd_stb_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 irq_n in reset", 32'(irq_n_o), 32'd1);
    check("R1 src in reset",   32'(src_o),   32'd0);
    check("R1 pend in reset",  32'(pend_o),  32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 irq_n after reset", 32'(irq_n_o), 32'd1);
    check("R1 src after reset",   32'(src_o),   32'd0);

    // table walk
    for (int v = 0; v < 9; v++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[v][26:23], v);
      mode_i   = VEC[v][22:21];
      fault_i  = VEC[v][20:15];
      wake_i   = VEC[v][14:12];
      rd_stb_i = VEC[v][11];
      @(negedge clk);
      check({tag, " irq_n"}, 32'(irq_n_o), 32'(VEC[v][0]));
      check({tag, " src"},   32'(src_o),   32'(VEC[v][10:2]));
      check({tag, " pend"},  32'(pend_o),  32'(VEC[v][1]));
      idle(PL + 2);
    end

    // R2 pulse width, then R3 held fault
    fault_i = 6'b001000;
    count_low(PL + 3, low);
    check("R2 pulse width", 32'(low), 32'(PL));
    count_low(10, low);
    check("R3 held fault no second pulse", 32'(low), 32'd0);
    fault_i = '0;
    @(negedge clk);
    fault_i = 6'b001000;
    count_low(PL + 3, low);
    check("R3 re-raised fault pulses again", 32'(low), 32'(PL));
    check("R7 switch 3 bit", 32'(src_o), 32'h008);
    fault_i = '0; rd_stb_i = 1'b1;
    @(negedge clk);
    rd_stb_i = 1'b0;
    check("R9 cleared", 32'(src_o), 32'd0);

    // R11 retrigger: second event two cycles after the first
    fault_i = 6'b000001;
    low = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!irq_n_o) low++;
      if (i == 1) fault_i = 6'b000011;
    end
    check("R11 stretched pulse", 32'(low), 32'(PL + 2));
    check("R7 ORed bits", 32'(src_o), 32'h003);
    check("R8 pend with bits", 32'(pend_o), 32'd1);

    // R5 wake in sleep mode ignored
    idle(2);
    rd_stb_i = 1'b1;
    @(negedge clk);
    rd_stb_i = 1'b0; mode_i = 2'd2; wake_i = 3'b111;
    count_low(PL + 2, low);
    check("R5 wake in sleep no pulse", 32'(low), 32'd0);
    check("R5 wake in sleep no bits", 32'(src_o), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule